// File: doc/BRIEF.md
# Multi-thread reorder-buffer head and tail selector

This block sits beside a reorder buffer that keeps a separate in-order queue for each hardware thread. Each cycle it is told, for every thread, whether the thread is running and whether its queue is empty. It also receives the sequence numbers of the oldest and youngest entries in that queue and whether the oldest entry may retire. From these it picks the thread that holds the globally oldest entry (the head) and the thread that holds the globally youngest entry (the tail). It also flags whether any thread is able to commit.

The block is a compare-and-select network followed by one rank of output registers. It keeps no storage of entries and does not retire anything. The retire and dispatch logic around it change the per-thread sequence numbers. The selector follows those changes one cycle later, so the head is recomputed after every retirement.

Top module: `rob_headtail_sel`

## Requirements
- R1: A thread takes part in head or tail selection only when its active bit is 1 and its empty flag is 0. A thread that is inactive or empty is never reported as head or tail, whatever its sequence numbers.
- R2: The head is the eligible thread with the smallest oldest-entry sequence number. Threads are scanned from ID 0 upward, and a later thread replaces the current pick only when its number is strictly smaller, so on a tie the lowest thread ID wins.
- R3: The tail is the eligible thread with the largest youngest-entry sequence number. A later thread replaces the current pick only when its number is strictly larger, so on a tie the lowest thread ID wins.
- R4: When no thread is eligible, both valid outputs are 0 and both thread-ID outputs are 0. When at least one thread is eligible, both valid outputs are 1.
- R5: A thread's head counts as ready only when the thread is active, is not empty, and has its ready bit set. A ready bit on an inactive or empty thread has no effect on the commit flag.
- R6: The commit flag is 1 exactly when at least one thread's head is ready in the sense of R5.
- R7: All outputs are registered. They reflect the inputs present at the previous rising clock edge, and an active-low asynchronous reset drives every output to 0.
- R8: The selection is recomputed every cycle. When a retirement raises the oldest sequence number of the current head thread, the head moves to the thread that is now oldest one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_act | input | NTHR | Per-thread active bit |
| thr_empty | input | NTHR | Per-thread queue-empty flag |
| old_seq | input | NTHR*SEQW | Oldest-entry sequence numbers, thread t in bits [t*SEQW +: SEQW] |
| young_seq | input | NTHR*SEQW | Youngest-entry sequence numbers, same packing |
| old_rdy | input | NTHR | Oldest entry of thread t may commit |
| head_vld | output | 1 | Head selection valid |
| head_tid | output | TW | Thread holding the oldest entry |
| tail_vld | output | 1 | Tail selection valid |
| tail_tid | output | TW | Thread holding the youngest entry |
| commit_ok | output | 1 | Some thread can commit |

## Verification
Every output is due exactly one rising edge after the inputs that produce it. The bench drives a new input pattern on a falling edge, lets one rising edge pass, and compares all outputs on the next falling edge before it drives the following pattern. The sweep covers every combination of active and empty masks for four threads. For each of those masks it applies several sequence-number patterns, ties among them, together with every ready mask. A directed retirement sequence then checks that the head moves on the cycle after the oldest number changes.

// File: rtl/rob_headtail_sel.sv
module rob_headtail_sel #(
  parameter int NTHR = 4,
  parameter int SEQW = 16,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NTHR-1:0]      thr_act,
  input  logic [NTHR-1:0]      thr_empty,
  input  logic [NTHR*SEQW-1:0] old_seq,
  input  logic [NTHR*SEQW-1:0] young_seq,
  input  logic [NTHR-1:0]      old_rdy,
  output logic                 head_vld,
  output logic [TW-1:0]        head_tid,
  output logic                 tail_vld,
  output logic [TW-1:0]        tail_tid,
  output logic                 commit_ok
);

  logic [NTHR-1:0] elig;
  logic            any_rdy;
  logic            hv_c, tv_c;
  logic [TW-1:0]   ht_c, tt_c;
  logic [SEQW-1:0] hs_c, ts_c;

  assign elig    = thr_act & ~thr_empty;
  assign any_rdy = |(elig & old_rdy);

  always_comb begin
    hv_c = 1'b0;
    ht_c = '0;
    hs_c = '0;
    tv_c = 1'b0;
    tt_c = '0;
    ts_c = '0;
    for (int t = 0; t < NTHR; t++) begin
      if (elig[t]) begin
        if (!hv_c || old_seq[t*SEQW +: SEQW] < hs_c) begin
          hv_c = 1'b1;
          ht_c = TW'(t);
          hs_c = old_seq[t*SEQW +: SEQW];
        end
        if (!tv_c || young_seq[t*SEQW +: SEQW] > ts_c) begin
          tv_c = 1'b1;
          tt_c = TW'(t);
          ts_c = young_seq[t*SEQW +: SEQW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_vld  <= 1'b0;
      head_tid  <= '0;
      tail_vld  <= 1'b0;
      tail_tid  <= '0;
      commit_ok <= 1'b0;
    end else begin
      head_vld  <= hv_c;
      head_tid  <= ht_c;
      tail_vld  <= tv_c;
      tail_tid  <= tt_c;
      commit_ok <= any_rdy;
    end
  end

endmodule

module rob_headtail_sel_chk #(
  parameter int NTHR = 4,
  parameter int TW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NTHR-1:0] thr_act,
  input logic [NTHR-1:0] thr_empty,
  input logic [NTHR-1:0] old_rdy,
  input logic            head_vld,
  input logic [TW-1:0]   head_tid,
  input logic            tail_vld,
  input logic [TW-1:0]   tail_tid,
  input logic            commit_ok
);

  logic [NTHR-1:0] elig_q, rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elig_q <= '0;
      rdy_q  <= '0;
    end else begin
      elig_q <= thr_act & ~thr_empty;
      rdy_q  <= old_rdy;
    end
  end

  p_head_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    head_vld |-> elig_q[head_tid]);
  p_tail_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tail_vld |-> elig_q[tail_tid]);
  p_none_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_q == '0) |-> (!head_vld && !tail_vld));
  p_some_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_q != '0) |-> (head_vld && tail_vld));
  p_commit_needs_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |-> |(elig_q & rdy_q));
  p_ready_gives_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |(elig_q & rdy_q) |-> commit_ok);

endmodule

bind rob_headtail_sel rob_headtail_sel_chk #(.NTHR(NTHR), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_act(thr_act), .thr_empty(thr_empty),
  .old_rdy(old_rdy), .head_vld(head_vld), .head_tid(head_tid),
  .tail_vld(tail_vld), .tail_tid(tail_tid), .commit_ok(commit_ok)
);

// File: tb/test_rob_headtail_sel.sv
module test_rob_headtail_sel;
  localparam int NTHR = 4;
  localparam int SEQW = 8;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NTHR-1:0]      thr_act = '0, thr_empty = '0, old_rdy = '0;
  logic [NTHR*SEQW-1:0] old_seq = '0, young_seq = '0;
  logic                 head_vld, tail_vld, commit_ok;
  logic [TW-1:0]        head_tid, tail_tid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rob_headtail_sel #(.NTHR(NTHR), .SEQW(SEQW)) i_rob_headtail_sel (
    .clk(clk), .rst_n(rst_n), .thr_act(thr_act), .thr_empty(thr_empty),
    .old_seq(old_seq), .young_seq(young_seq), .old_rdy(old_rdy),
    .head_vld(head_vld), .head_tid(head_tid), .tail_vld(tail_vld),
    .tail_tid(tail_tid), .commit_ok(commit_ok)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (act=%b empty=%b rdy=%b)",
               req, act, exp, thr_act, thr_empty, old_rdy);
    end
  endtask

  task automatic check_all();
    int hv, ht, tv, tt, cm, hs, ts;
    logic [SEQW-1:0] o, y;
    hv = 0; ht = 0; tv = 0; tt = 0; cm = 0; hs = 0; ts = 0;
    for (int t = 0; t < NTHR; t++) begin
      if (thr_act[t] && !thr_empty[t]) begin
        o = old_seq[t*SEQW +: SEQW];
        y = young_seq[t*SEQW +: SEQW];
        if (hv == 0 || int'(o) < hs) begin hv = 1; ht = t; hs = int'(o); end
        if (tv == 0 || int'(y) > ts) begin tv = 1; tt = t; ts = int'(y); end
        if (old_rdy[t]) cm = 1;
      end
    end
    @(negedge clk);
    chk("R4 head_vld", int'(head_vld), hv);
    chk("R2 head_tid", int'(head_tid), ht);
    chk("R4 tail_vld", int'(tail_vld), tv);
    chk("R3 tail_tid", int'(tail_tid), tt);
    chk("R6 commit_ok", int'(commit_ok), cm);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset head_vld", int'(head_vld), 0);
    chk("R7 reset tail_vld", int'(tail_vld), 0);
    chk("R7 reset commit_ok", int'(commit_ok), 0);
    rst_n = 1'b1;
    // R1 R2 R3 R4 R5 R6: sweep masks, sequence patterns and ready masks
    for (int m = 0; m < 256; m++) begin
      for (int p = 0; p < 4; p++) begin
        for (int r = 0; r < 16; r++) begin
          thr_act   = m[3:0];
          thr_empty = m[7:4];
          old_rdy   = r[3:0];
          for (int t = 0; t < NTHR; t++) begin
            if (p == 2) begin
              old_seq[t*SEQW +: SEQW]   = 8'd40;
              young_seq[t*SEQW +: SEQW] = 8'd90;
            end else if (p == 3) begin
              old_seq[t*SEQW +: SEQW]   = 8'((t % 2) * 10 + 5);
              young_seq[t*SEQW +: SEQW] = 8'(200 - (t % 2) * 10);
            end else begin
              old_seq[t*SEQW +: SEQW]   = 8'((t * 37 + p * 91 + m * 3) % 120);
              young_seq[t*SEQW +: SEQW] = 8'(128 + (t * 53 + p * 17 + m * 5) % 120);
            end
          end
          check_all();
        end
      end
    end
    // R8: retirement on the head thread moves the head the cycle after
    thr_act = 4'b1111; thr_empty = 4'b0000; old_rdy = 4'b0001;
    old_seq = {8'd30, 8'd20, 8'd25, 8'd10};
    young_seq = {8'd60, 8'd70, 8'd65, 8'd50};
    @(negedge clk);
    chk("R8 head before retire", int'(head_tid), 0);
    old_seq[0 +: SEQW] = 8'd28;
    @(negedge clk);
    chk("R8 head after retire", int'(head_tid), 2);
    old_seq[2*SEQW +: SEQW] = 8'd35;
    @(negedge clk);
    chk("R8 head after second retire", int'(head_tid), 1);
    // R7: output still shows previous inputs half a cycle after a change
    thr_act = 4'b0000;
    #1;
    chk("R7 registered hold", int'(head_vld), 1);
    @(negedge clk);
    chk("R7 registered update", int'(head_vld), 0);
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule